// File: doc/BRIEF.md
# Constant-Time Modular Exponentiator

This block computes `base^exp mod m` for small operands (16 bits by default) so that neither its latency nor its sequence of internal operations depends on the exponent. A caller presents base, exponent and modulus with a one-cycle `start` pulse while the block is idle. The block pulses `done` when the result is ready, at a fixed cycle count after the accepted start.

The exponent is scanned from its top bit down, with the running value starting at 1. For every bit position the running value is squared modulo m, and the square is then multiplied by the base modulo m, whatever the bit is. The new running value is formed without a branch. A mask is made by copying the bit across the word, and the kept word is `(product & mask) | (square & ~mask)`. All arithmetic is done by one iterative shift-add modular multiplier. It processes one multiplier bit per cycle and uses at most two trial subtractions per step. The base is first brought below m with one extra pass through the same multiplier, so a base at or above the modulus is allowed.

A modulus of 0 or 1 is treated as an error. The result is 0, an error flag is raised with `done`, and the run still takes the full fixed latency.

Top module: `ct_modexp`

## Requirements
- R1: For a modulus m of 2 or more, `result` equals base^exp mod m when `done` is high, for any 16-bit base (including base >= m) and any 16-bit exponent.
- R2: The exponent is consumed from its most significant bit with the running value starting at 1, so an exponent of 0 returns 1 and a base of 0 with a non-zero exponent returns 0.
- R3: With WIDTH = W and EXP_WIDTH = E, `done` rises exactly (2E+1)(W+1) clock edges after the edge that accepted `start` (561 for the defaults), whatever the operand values.
- R4: A squaring and a multiplication by the base happen for every exponent bit, so an all-zero exponent and an all-ones exponent give identical latency.
- R5: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after the accepting edge until the done cycle, and `busy` is low while `done` is high.
- R6: `start` is ignored while `busy` is high: a run interrupted by start pulses with other operands keeps its latency and result.
- R7: A modulus of 0 or 1 gives `result` = 0 and `modErr` = 1 with `done`, after the same fixed latency as a valid run.
- R8: For a modulus of 2 or more, `modErr` is 0 with `done`, and `result` is below the modulus.
- R9: After reset `busy`, `done`, `modErr` and `result` are all 0.
- R10: `result` and `modErr` hold their values from the done cycle until the next accepted start completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| baseIn | input | WIDTH | Base operand, sampled on the accepting edge |
| expIn | input | EXP_WIDTH | Exponent, sampled on the accepting edge |
| modIn | input | WIDTH | Modulus, sampled on the accepting edge |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | WIDTH | base^exp mod m, held until the next completion |
| modErr | output | 1 | Modulus was 0 or 1 for the last run |

## Verification
The hardest case to reach from the ports is a start request that arrives while a run is in flight. It happens only if the caller misbehaves, and it must change neither the timing nor the value of the run. The bench drives it deliberately: a few hundred cycles into a run it pulses `start` with unrelated operands, then checks that `done` still comes at the fixed edge with the original answer. The constant-latency claim is checked as a measured edge count compared against the closed-form (2E+1)(W+1). It is measured on exponents that are all zeros, all ones and mixed, and on invalid moduli.

// File: rtl/ct_modexp_pkg.sv
package ct_modexp_pkg;

  // Operand routing for the shared modular multiplier
  typedef enum logic [1:0] {
    OP_REDUCE = 2'd0,  // 1 * base mod m, taken straight from the ports
    OP_SQ_ACC = 2'd1,  // running value squared, from the register
    OP_SQ_NEW = 2'd2,  // freshly selected value squared
    OP_MULT   = 2'd3   // fresh square times reduced base
  } mulOp_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic   load;     // latch operands, running value := 1
    logic   mulGo;    // launch one modular multiply
    mulOp_e op;       // operand routing for that multiply
    logic   capBase;  // store the reduced base
    logic   capSq;    // store the square
    logic   capAcc;   // masked select into the running value, shift exponent
    logic   finish;   // publish result and raise done
  } dpCtrl_t;

endpackage

// File: rtl/ct_modmul.sv
// Interleaved shift-add modular multiplier. One multiplier bit per cycle,
// most significant first, with two trial subtractions per step. The number
// of cycles never depends on operand values.
module ct_modmul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opM,
  output logic [W-1:0] prod,
  output logic         mulDone
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] TOP_IDX = CW'(W - 1);

  logic [W-1:0]  aQ, bQ, mQ, accQ;
  logic [CW-1:0] bitIdx;
  logic          running;
  logic [W-1:0]  stepVal;

  always_comb begin
    logic [W+1:0] twice, mOnce, mTwice, trial;
    twice  = {1'b0, accQ, 1'b0} + (bQ[bitIdx] ? {2'b00, aQ} : '0);
    mOnce  = {2'b00, mQ};
    mTwice = {1'b0, mQ, 1'b0};
    if (twice >= mTwice)      trial = twice - mTwice;
    else if (twice >= mOnce)  trial = twice - mOnce;
    else                      trial = twice;
    stepVal = W'(trial);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ      <= '0;
      bQ      <= '0;
      mQ      <= '0;
      accQ    <= '0;
      bitIdx  <= '0;
      running <= 1'b0;
      mulDone <= 1'b0;
    end else begin
      mulDone <= 1'b0;
      if (go) begin
        aQ      <= opA;
        bQ      <= opB;
        mQ      <= opM;
        accQ    <= '0;
        bitIdx  <= TOP_IDX;
        running <= 1'b1;
      end else if (running) begin
        accQ <= stepVal;
        if (bitIdx == '0) begin
          running <= 1'b0;
          mulDone <= 1'b1;
        end else begin
          bitIdx <= bitIdx - 1'b1;
        end
      end
    end
  end

  assign prod = accQ;

endmodule

// File: rtl/ct_modexp_ctrl.sv
// Sequencer: reduce the base, then a fixed square/multiply pair per exponent bit.
module ct_modexp_ctrl
  import ct_modexp_pkg::*;
#(
  parameter int E = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    mulDone,
  output logic    busy,
  output dpCtrl_t ctl
);

  localparam int BW = (E > 2) ? $clog2(E) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(E - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RED  = 2'd1,
    ST_SQ   = 2'd2,
    ST_MUL  = 2'd3
  } state_e;

  state_e     stateQ, stateD;
  logic [BW-1:0] bitsLeftQ, bitsLeftD;

  always_comb begin
    stateD    = stateQ;
    bitsLeftD = bitsLeftQ;
    ctl       = '0;
    ctl.op    = OP_REDUCE;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          ctl.mulGo = 1'b1;
          ctl.op    = OP_REDUCE;
          bitsLeftD = LAST_BIT;
          stateD    = ST_RED;
        end
      end
      ST_RED: begin
        if (mulDone) begin
          ctl.capBase = 1'b1;
          ctl.mulGo   = 1'b1;
          ctl.op      = OP_SQ_ACC;
          stateD      = ST_SQ;
        end
      end
      ST_SQ: begin
        if (mulDone) begin
          ctl.capSq = 1'b1;
          ctl.mulGo = 1'b1;
          ctl.op    = OP_MULT;
          stateD    = ST_MUL;
        end
      end
      ST_MUL: begin
        if (mulDone) begin
          ctl.capAcc = 1'b1;
          if (bitsLeftQ == '0) begin
            ctl.finish = 1'b1;
            stateD     = ST_IDLE;
          end else begin
            ctl.mulGo = 1'b1;
            ctl.op    = OP_SQ_NEW;
            bitsLeftD = bitsLeftQ - 1'b1;
            stateD    = ST_SQ;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      bitsLeftQ <= '0;
    end else begin
      stateQ    <= stateD;
      bitsLeftQ <= bitsLeftD;
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/ct_modexp_dp.sv
// Datapath: operand registers, branchless masked select, shared multiplier.
module ct_modexp_dp
  import ct_modexp_pkg::*;
#(
  parameter int W = 16,
  parameter int E = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctl,
  input  logic [W-1:0] baseIn,
  input  logic [E-1:0] expIn,
  input  logic [W-1:0] modIn,
  output logic         mulDone,
  output logic [W-1:0] result,
  output logic         done,
  output logic         modErr
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] baseQ, sqQ, accQ, modQ;
  logic [E-1:0] expQ;
  logic         badModQ;

  logic [W-1:0] mulA, mulB, mulM, mulProd;
  logic [W-1:0] keepMask, newAcc;

  // Mask is the current exponent bit copied across the word; no branch.
  assign keepMask = {W{expQ[E-1]}};
  assign newAcc   = (mulProd & keepMask) | (sqQ & ~keepMask);

  always_comb begin
    mulM = modQ;
    unique case (ctl.op)
      OP_REDUCE: begin
        mulA = ONE;
        mulB = baseIn;
        mulM = modIn;
      end
      OP_SQ_ACC: begin
        mulA = accQ;
        mulB = accQ;
      end
      OP_SQ_NEW: begin
        mulA = newAcc;
        mulB = newAcc;
      end
      default: begin
        mulA = mulProd;
        mulB = baseQ;
      end
    endcase
  end

  ct_modmul #(.W(W)) uMul (
    .clk     (clk),
    .rstN    (rstN),
    .go      (ctl.mulGo),
    .opA     (mulA),
    .opB     (mulB),
    .opM     (mulM),
    .prod    (mulProd),
    .mulDone (mulDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ   <= '0;
      sqQ     <= '0;
      accQ    <= '0;
      modQ    <= '0;
      expQ    <= '0;
      badModQ <= 1'b0;
      result  <= '0;
      done    <= 1'b0;
      modErr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        accQ    <= ONE;
        modQ    <= modIn;
        expQ    <= expIn;
        badModQ <= (modIn < W'(2));
      end
      if (ctl.capBase) baseQ <= mulProd;
      if (ctl.capSq)   sqQ   <= mulProd;
      if (ctl.capAcc) begin
        accQ <= newAcc;
        expQ <= expQ << 1;
      end
      if (ctl.finish) begin
        result <= badModQ ? '0 : newAcc;
        modErr <= badModQ;
        done   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ct_modexp.sv
module ct_modexp
  import ct_modexp_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int EXP_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [WIDTH-1:0]     baseIn,
  input  logic [EXP_WIDTH-1:0] expIn,
  input  logic [WIDTH-1:0]     modIn,
  output logic                 busy,
  output logic                 done,
  output logic [WIDTH-1:0]     result,
  output logic                 modErr
);

  dpCtrl_t ctl;
  logic    mulDone;

  ct_modexp_ctrl #(.E(EXP_WIDTH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mulDone (mulDone),
    .busy    (busy),
    .ctl     (ctl)
  );

  ct_modexp_dp #(.W(WIDTH), .E(EXP_WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .baseIn  (baseIn),
    .expIn   (expIn),
    .modIn   (modIn),
    .mulDone (mulDone),
    .result  (result),
    .done    (done),
    .modErr  (modErr)
  );

endmodule

// File: rtl/ct_modexp_chk.sv
module ct_modexp_chk #(
  parameter int W = 16,
  parameter int E = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic         modErr,
  input logic [W-1:0] modIn
);

  localparam int LAT = (2 * E + 1) * (W + 1);

  logic [31:0]  sinceStart;
  logic [W-1:0] modHeld;
  logic         accepted;

  assign accepted = start && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStart <= '0;
      modHeld    <= '0;
    end else begin
      if (accepted) begin
        sinceStart <= 32'd1;
        modHeld    <= modIn;
      end else if (done) begin
        sinceStart <= '0;
      end else if (sinceStart != '0) begin
        sinceStart <= sinceStart + 32'd1;
      end
    end
  end

  // R3 / R4 / R7: done arrives exactly LAT edges after the accepting edge
  p_fixed_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceStart == 32'(LAT + 1)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_idle_at_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6: once running, only completion ends busy; extra start pulses change nothing
  p_run_continues_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy || done));

  p_bad_mod_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && modErr) |-> (result == '0 && modHeld < W'(2)));

  p_below_mod_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modErr) |-> (result < modHeld));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(modErr)));

endmodule

bind ct_modexp ct_modexp_chk #(.W(WIDTH), .E(EXP_WIDTH)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .modErr (modErr),
  .modIn  (modIn)
);

// File: tb/sim_ct_modexp.sv
`timescale 1ns/1ps
module sim_ct_modexp;

  localparam int W   = 16;
  localparam int E   = 16;
  localparam int LAT = (2 * E + 1) * (W + 1);
  localparam int NV  = 12;

  // {base, exponent, modulus}
  localparam logic [47:0] VEC [NV] = '{
    {16'd3,     16'd0,      16'd7},
    {16'd2,     16'd10,     16'd1000},
    {16'd5,     16'd3,      16'd13},
    {16'd65535, 16'd65535,  16'd65521},
    {16'd12345, 16'd54321,  16'd40000},
    {16'd7,     16'hFFFF,   16'd65535},
    {16'd0,     16'd5,      16'd11},
    {16'd0,     16'd0,      16'd11},
    {16'd40000, 16'd3,      16'd17},
    {16'd1,     16'd1,      16'd2},
    {16'd65535, 16'd1,      16'd65535},
    {16'd2,     16'd16,     16'd65535}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] baseIn = '0;
  logic [E-1:0] expIn = '0;
  logic [W-1:0] modIn = '0;
  logic         busy, done, modErr;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit summaryDone = 0;

  always #2 clk = ~clk;

  ct_modexp u0 (
    .clk(clk), .rstN(rstN), .start(start), .baseIn(baseIn), .expIn(expIn),
    .modIn(modIn), .busy(busy), .done(done), .result(result), .modErr(modErr)
  );

  function automatic longint unsigned refPow(longint unsigned b,
                                             longint unsigned e,
                                             longint unsigned m);
    longint unsigned r, x, k;
    if (m < 2) return 0;
    r = 1 % m;
    x = b % m;
    k = e;
    while (k != 0) begin
      if (k[0]) r = (r * x) % m;
      x = (x * x) % m;
      k = k >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input bit ok,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // Launch one run; optionally pulse start with other operands mid-run.
  task automatic runOp(input logic [W-1:0] b, input logic [E-1:0] e,
                       input logic [W-1:0] m, input bit poke,
                       output int lat, output logic [W-1:0] res,
                       output logic err, output bit busyOk);
    int n = 0;
    busyOk = 1;
    @(negedge clk);
    baseIn = b; expIn = e; modIn = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (!busy) busyOk = 0;
    while (!done && n < LAT + 50) begin
      if (poke && n == 200) begin
        baseIn = 16'hBEEF; expIn = 16'h1234; modIn = 16'd97; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
      if (!done && !busy) busyOk = 0;
    end
    start = 1'b0;
    if (done && busy) busyOk = 0;
    lat = n;
    res = result;
    err = modErr;
  endtask

  initial begin
    int lat;
    logic [W-1:0] res;
    logic err;
    bit busyOk;
    int latZero, latOnes;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", busy == 0 && done == 0 && result == 0 && modErr == 0,
          {busy, done, modErr, result}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] vb, vm;
      logic [E-1:0] ve;
      longint unsigned expVal;
      {vb, ve, vm} = VEC[i];
      expVal = refPow(vb, ve, vm);
      runOp(vb, ve, vm, 0, lat, res, err, busyOk);
      check("R1 result", res == W'(expVal), res, expVal);
      check("R3 latency", lat == LAT + 1, lat, LAT + 1);
      check("R8 no error", err == 0 && res < vm, err, 0);
      check("R5 busy window", busyOk, busyOk, 1);
      @(negedge clk);
      check("R5 done one cycle", done == 0, done, 0);
    end

    // R2: exponent 0 gives 1; zero base with non-zero exponent gives 0
    runOp(16'd999, 16'd0, 16'd1234, 0, lat, res, err, busyOk);
    check("R2 exp zero", res == 1, res, 1);
    runOp(16'd0, 16'h8000, 16'd1234, 0, lat, res, err, busyOk);
    check("R2 zero base", res == 0, res, 0);

    // R4: all-zero and all-ones exponent cost the same
    runOp(16'd3, 16'h0000, 16'd65521, 0, latZero, res, err, busyOk);
    runOp(16'd3, 16'hFFFF, 16'd65521, 0, latOnes, res, err, busyOk);
    check("R4 equal latency", latZero == latOnes, latOnes, latZero);
    check("R4 ones result", res == W'(refPow(3, 16'hFFFF, 65521)), res,
          refPow(3, 16'hFFFF, 65521));

    // R7: modulus 0 and 1
    runOp(16'd5, 16'd7, 16'd0, 0, lat, res, err, busyOk);
    check("R7 mod0 result", res == 0 && err == 1, {err, res}, 17'h10000);
    check("R7 mod0 latency", lat == LAT + 1, lat, LAT + 1);
    runOp(16'd5, 16'd7, 16'd1, 0, lat, res, err, busyOk);
    check("R7 mod1 result", res == 0 && err == 1, {err, res}, 17'h10000);

    // R10: error flag clears on the next valid run; values hold while idle
    runOp(16'd6, 16'd5, 16'd101, 0, lat, res, err, busyOk);
    repeat (20) @(negedge clk);
    check("R10 hold result", result == W'(refPow(6, 5, 101)), result, refPow(6, 5, 101));
    check("R10 hold flag", modErr == 0, modErr, 0);

    // R6: start pulsed mid-run with other operands is ignored
    runOp(16'd12345, 16'hA5A5, 16'd60001, 1, lat, res, err, busyOk);
    check("R6 result kept", res == W'(refPow(12345, 16'hA5A5, 60001)), res,
          refPow(12345, 16'hA5A5, 60001));
    check("R6 latency kept", lat == LAT + 1, lat, LAT + 1);
    repeat (5) @(negedge clk);
    check("R6 no second run", busy == 0 && done == 0, {busy, done}, 0);

    finishRun();
  end

endmodule